// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This combinational block sits beside the execute stage of a five-stage in-order pipeline. For each of the two ALU operands it compares the source register number of the instruction in execute against the destination register numbers of the two older instructions that have not yet retired. One of those is in the memory stage and the other is in write-back. When a match is found, the operand comes from the pipeline register instead of the value read from the register file during decode. An instruction one or two slots behind its producer therefore gets the result without waiting for write-back. When both older stages match, the memory-stage result is chosen because it is the newer one.

A second function covers the remaining overlap. A decode-stage register read that targets the register being written back in the same cycle returns the value being written, not the old content of the register file. Both functions ignore a stage whose write enable is low, and both never bypass register 0, which always reads as its file value. Detecting load-use stalls is handled elsewhere.

Top module: `alu_fwd_unit`

## Requirements
- R1: When the memory stage writes a nonzero register equal to an operand's source, that operand's select is 2'b10 and its value is the memory-stage result.
- R2: When only the write-back stage writes a nonzero register equal to an operand's source, that operand's select is 2'b01 and its value is the write-back result.
- R3: When both stages match the same operand source, the memory stage wins: select 2'b10 and the memory-stage result.
- R4: When neither stage matches, the select is 2'b00 and the operand is the register-file value carried from decode.
- R5: A stage whose write enable is 0 never supplies an operand, whatever its destination number is.
- R6: A source or destination register number of 0 never causes forwarding; such an operand uses select 2'b00.
- R7: The two operands are resolved independently: each has its own select and multiplexer, and each can take a different source in the same cycle.
- R8: A decode read of register r returns the write-back value when write-back writes r with enable 1 and r is nonzero.
- R9: The decode bypass is inactive for register 0 or with write-back enable 0; the read then returns the raw register-file data.
- R10: A select code never takes the unused value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | ADDR_W | First source register of the instruction in execute |
| ex_rt_i | input | ADDR_W | Second source register of the instruction in execute |
| ex_rs_val_i | input | DATA_W | Register-file value for the first source, read in decode |
| ex_rt_val_i | input | DATA_W | Register-file value for the second source, read in decode |
| mem_rd_i | input | ADDR_W | Destination register held in the memory stage |
| mem_we_i | input | 1 | Register write enable of the memory stage |
| mem_result_i | input | DATA_W | Result held in the memory stage |
| wb_rd_i | input | ADDR_W | Destination register held in write-back |
| wb_we_i | input | 1 | Register write enable of write-back |
| wb_result_i | input | DATA_W | Value being written back |
| sel_a_o | output | 2 | Select of the first operand: 00 file, 10 memory stage, 01 write-back |
| sel_b_o | output | 2 | Select of the second operand, same encoding |
| opnd_a_o | output | DATA_W | First ALU operand after forwarding |
| opnd_b_o | output | DATA_W | Second ALU operand after forwarding |
| dec_rs_i | input | ADDR_W | First register number read in decode |
| dec_rt_i | input | ADDR_W | Second register number read in decode |
| dec_rs_raw_i | input | DATA_W | Raw register-file data for the first decode read |
| dec_rt_raw_i | input | DATA_W | Raw register-file data for the second decode read |
| dec_rs_val_o | output | DATA_W | First decode read after the write-back bypass |
| dec_rt_val_o | output | DATA_W | Second decode read after the write-back bypass |

## Verification
The bench sweeps every combination of both operand sources, both stage destinations and both write enables over registers 0 to 3. Each of the three data sources carries a distinct tag, so a wrong select or a wrong multiplexer leg shows up as a wrong value. The sweep separates single-stage hits, double hits where priority decides, disabled stages, and the register-0 cases. It also covers operand pairs that resolve to different sources in the same cycle. A second sweep over the decode read numbers against the write-back number and enable checks the bypass, including register 0. Directed cases on register 31 exercise the full width of the number compare.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'b00,
    FWD_WB = 2'b01,
    FWD_EX = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output fwd_sel_e          sel_o
);
  logic mem_hit, wb_hit;

  assign mem_hit = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign wb_hit  = wb_we_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_i);

  // nearer stage holds the newer value
  always_comb begin
    if (mem_hit)     sel_o = FWD_EX;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    p_sel_legal_r10: assert ($onehot0(sel_o))
      else $error("select code 2'b11 produced");
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_val_i,
  input  logic [DATA_W-1:0] mem_val_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [DATA_W-1:0] opnd_o
);
  always_comb begin
    unique case (sel_i)
      FWD_EX:  opnd_o = mem_val_i;
      FWD_WB:  opnd_o = wb_val_i;
      default: opnd_o = rf_val_i;
    endcase
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [ADDR_W-1:0] wb_rd_i,
  input  logic              wb_we_i,
  input  logic [DATA_W-1:0] wb_val_i,
  output logic [DATA_W-1:0] val_o
);
  logic hit;

  assign hit   = wb_we_i && (wb_rd_i != '0) && (wb_rd_i == rd_addr_i);
  assign val_o = hit ? wb_val_i : raw_i;

  always_comb begin
    p_zero_raw_r9: assert (rd_addr_i != '0 || val_o == raw_i)
      else $error("register 0 read was bypassed");
  end
endmodule

// File: rtl/alu_fwd_unit.sv
module alu_fwd_unit
  import fwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] ex_rs_i,
  input  logic [ADDR_W-1:0] ex_rt_i,
  input  logic [DATA_W-1:0] ex_rs_val_i,
  input  logic [DATA_W-1:0] ex_rt_val_i,
  input  logic [ADDR_W-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic [DATA_W-1:0] mem_result_i,
  input  logic [ADDR_W-1:0] wb_rd_i,
  input  logic              wb_we_i,
  input  logic [DATA_W-1:0] wb_result_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o,
  input  logic [ADDR_W-1:0] dec_rs_i,
  input  logic [ADDR_W-1:0] dec_rt_i,
  input  logic [DATA_W-1:0] dec_rs_raw_i,
  input  logic [DATA_W-1:0] dec_rt_raw_i,
  output logic [DATA_W-1:0] dec_rs_val_o,
  output logic [DATA_W-1:0] dec_rt_val_o
);
  localparam int NUM_OPND = 2;
  localparam int NUM_RD   = 2;

  logic [ADDR_W-1:0] src     [NUM_OPND];
  logic [DATA_W-1:0] rf_val  [NUM_OPND];
  fwd_sel_e          sel     [NUM_OPND];
  logic [DATA_W-1:0] opnd    [NUM_OPND];

  logic [ADDR_W-1:0] rd_addr [NUM_RD];
  logic [DATA_W-1:0] rd_raw  [NUM_RD];
  logic [DATA_W-1:0] rd_val  [NUM_RD];

  assign src[0]     = ex_rs_i;
  assign src[1]     = ex_rt_i;
  assign rf_val[0]  = ex_rs_val_i;
  assign rf_val[1]  = ex_rt_val_i;
  assign sel_a_o    = sel[0];
  assign sel_b_o    = sel[1];
  assign opnd_a_o   = opnd[0];
  assign opnd_b_o   = opnd[1];

  assign rd_addr[0]   = dec_rs_i;
  assign rd_addr[1]   = dec_rt_i;
  assign rd_raw[0]    = dec_rs_raw_i;
  assign rd_raw[1]    = dec_rt_raw_i;
  assign dec_rs_val_o = rd_val[0];
  assign dec_rt_val_o = rd_val[1];

  for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
    fwd_select #(.ADDR_W(ADDR_W)) u_sel (
      .src_i    (src[i]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[i])
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i     (sel[i]),
      .rf_val_i  (rf_val[i]),
      .mem_val_i (mem_result_i),
      .wb_val_i  (wb_result_i),
      .opnd_o    (opnd[i])
    );

    always_comb begin
      p_ex_value_r1: assert (sel[i] != FWD_EX || opnd[i] == mem_result_i)
        else $error("memory-stage select without its value");
      p_wb_value_r2: assert (sel[i] != FWD_WB || opnd[i] == wb_result_i)
        else $error("write-back select without its value");
      p_idle_rf_r5: assert (mem_we_i || wb_we_i || sel[i] == FWD_RF)
        else $error("forwarding with both enables low");
      p_src_zero_r6: assert (src[i] != '0 || sel[i] == FWD_RF)
        else $error("register 0 forwarded");
    end
  end

  for (genvar j = 0; j < NUM_RD; j++) begin : g_rd
    rf_bypass #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_byp (
      .rd_addr_i (rd_addr[j]),
      .raw_i     (rd_raw[j]),
      .wb_rd_i   (wb_rd_i),
      .wb_we_i   (wb_we_i),
      .wb_val_i  (wb_result_i),
      .val_o     (rd_val[j])
    );

    always_comb begin
      p_byp_off_r9: assert (wb_we_i || rd_val[j] == rd_raw[j])
        else $error("bypass active with write-back disabled");
    end
  end
endmodule

// File: tb/alu_fwd_unit_test.sv
module alu_fwd_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [AW-1:0] ex_rs, ex_rt, mem_rd, wb_rd, dec_rs, dec_rt;
  logic          mem_we, wb_we;
  logic [DW-1:0] ex_rs_val, ex_rt_val, mem_result, wb_result, dec_rs_raw, dec_rt_raw;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, dec_rs_val, dec_rt_val;

  int checks = 0;
  int errors = 0;

  alu_fwd_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rs_val_i(ex_rs_val), .ex_rt_val_i(ex_rt_val),
    .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_result_i(mem_result),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we), .wb_result_i(wb_result),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .opnd_a_o(opnd_a), .opnd_b_o(opnd_b),
    .dec_rs_i(dec_rs), .dec_rt_i(dec_rt), .dec_rs_raw_i(dec_rs_raw), .dec_rt_raw_i(dec_rt_raw),
    .dec_rs_val_o(dec_rs_val), .dec_rt_val_o(dec_rt_val)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
    if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd != 0 && wb_rd == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_for(input logic [AW-1:0] s);
    logic mh, wh;
    mh = mem_we && mem_rd != 0 && mem_rd == s;
    wh = wb_we && wb_rd != 0 && wb_rd == s;
    if (s == 0)                          return "R6";
    if (mh && wh)                        return "R3";
    if (mh)                              return "R1";
    if (wh)                              return "R2";
    if ((!mem_we && mem_rd == s) || (!wb_we && wb_rd == s)) return "R5";
    return "R4";
  endfunction

  task automatic check_opnds();
    logic [1:0] ea, eb;
    logic [DW-1:0] va, vb;
    ea = exp_sel(ex_rs);
    eb = exp_sel(ex_rt);
    va = (ea == 2'b10) ? mem_result : (ea == 2'b01) ? wb_result : ex_rs_val;
    vb = (eb == 2'b10) ? mem_result : (eb == 2'b01) ? wb_result : ex_rt_val;
    check(tag_for(ex_rs), "sel_a", {30'd0, sel_a}, {30'd0, ea});
    check(tag_for(ex_rs), "opnd_a", opnd_a, va);
    check(tag_for(ex_rt), "sel_b", {30'd0, sel_b}, {30'd0, eb});
    check(tag_for(ex_rt), "opnd_b", opnd_b, vb);
    if (sel_a == 2'b11 || sel_b == 2'b11) check("R10", "select 11", 32'd1, 32'd0);
    if (ea != eb) check("R7", "independent sel", {30'd0, sel_a ^ sel_b}, {30'd0, ea ^ eb});
  endtask

  task automatic check_bypass();
    logic [DW-1:0] er, et;
    er = (wb_we && wb_rd != 0 && wb_rd == dec_rs) ? wb_result : dec_rs_raw;
    et = (wb_we && wb_rd != 0 && wb_rd == dec_rt) ? wb_result : dec_rt_raw;
    check((er == wb_result) ? "R8" : "R9", "dec_rs_val", dec_rs_val, er);
    check((et == wb_result) ? "R8" : "R9", "dec_rt_val", dec_rt_val, et);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ex_rs = 0; ex_rt = 0; mem_rd = 0; wb_rd = 0; dec_rs = 0; dec_rt = 0;
    mem_we = 0; wb_we = 0;
    ex_rs_val = 32'hA5A5_0001; ex_rt_val = 32'hA5A5_0002;
    mem_result = 32'hEEEE_1111; wb_result = 32'hBBBB_2222;
    dec_rs_raw = 32'hC0C0_0003; dec_rt_raw = 32'hC0C0_0004;

    // idle state: everything from the register file
    @(negedge clk); #1;
    check("R4", "idle sel_a", {30'd0, sel_a}, 32'd0);
    check("R4", "idle opnd_a", opnd_a, 32'hA5A5_0001);
    check("R9", "idle dec_rs", dec_rs_val, 32'hC0C0_0003);

    // exhaustive forwarding sweep over registers 0..3
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++)
            for (int e = 0; e < 4; e++) begin
              @(negedge clk);
              ex_rs = AW'(a); ex_rt = AW'(b); mem_rd = AW'(m); wb_rd = AW'(w);
              mem_we = e[1]; wb_we = e[0];
              ex_rs_val  = 32'h1000_0000 + 32'(a * 16 + b);
              ex_rt_val  = 32'h2000_0000 + 32'(b * 16 + a);
              mem_result = 32'hE000_0000 + 32'(m * 16 + e);
              wb_result  = 32'hB000_0000 + 32'(w * 16 + e);
              #1;
              check_opnds();
            end

    // decode bypass sweep
    for (int r = 0; r < 4; r++)
      for (int t = 0; t < 4; t++)
        for (int w = 0; w < 4; w++)
          for (int e = 0; e < 2; e++) begin
            @(negedge clk);
            dec_rs = AW'(r); dec_rt = AW'(t); wb_rd = AW'(w); wb_we = e[0];
            dec_rs_raw = 32'h3000_0000 + 32'(r);
            dec_rt_raw = 32'h4000_0000 + 32'(t);
            wb_result  = 32'h5000_0000 + 32'(w);
            #1;
            check_bypass();
          end

    // high register numbers: full-width compare
    @(negedge clk);
    ex_rs = 5'd31; ex_rt = 5'd15; mem_rd = 5'd31; mem_we = 1; wb_rd = 5'd15; wb_we = 1;
    mem_result = 32'hDEAD_0031; wb_result = 32'hBEEF_0015;
    dec_rs = 5'd15; dec_rt = 5'd14;
    #1;
    check("R1", "r31 opnd_a", opnd_a, 32'hDEAD_0031);
    check("R2", "r15 opnd_b", opnd_b, 32'hBEEF_0015);
    check("R7", "r31 sel_a", {30'd0, sel_a}, 32'd2);
    check("R7", "r15 sel_b", {30'd0, sel_b}, 32'd1);
    check("R8", "r15 dec_rs", dec_rs_val, 32'hBEEF_0015);
    check("R9", "r14 dec_rt", dec_rt_val, dec_rt_raw);

    @(negedge clk);
    ex_rs = 5'd30; mem_rd = 5'd31; wb_rd = 5'd14;
    #1;
    check("R4", "r30 miss sel_a", {30'd0, sel_a}, 32'd0);
    check("R4", "r30 miss opnd_a", opnd_a, ex_rs_val);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule